// File: doc/BRIEF.md
# LDPC Early-Termination Parity Sensing Controller

This block decides when an iterative LDPC decoder may stop working on a block. The code is small and its parity-check matrix is a fixed parameter with m rows over n bits. Every decoding iteration is a frame of eight clock slots, numbered 0 to 7 and counted from the first cycle after a start pulse. The earlier slots carry the bit-to-check messages. In slot 5 each bit node puts the hard-decision sign of its a-posteriori value onto the otherwise idle lines. The block then checks every row of the matrix against those signs and merges the results into a single error-free flag.

A start pulse loads a new block and turns the datapath clock on. The block ends in one of two ways. In the first, the exact check passes in some iteration and the block stops early. In the second, the iteration cap is reached and the block is released with its checks still failing. When the block ends, the controller gives a one-cycle done strobe together with the decided word, the number of iterations used and the exit reason. It then gates the decoder clock off through a latch-based gate that cannot glitch. A selectable approximate mode forms the check from the per-edge message signs instead. Its decision arrives two cycles later.

Top module: `ldpc_et_ctrl`

## Requirements
- R1: During and after reset, `done_o`, `exit_clean_o` and `dp_clk_en_o` are 0, `iter_count_o` is 0 and `dp_clk_o` stays low.
- R2: The cycle after `start_i` is seen, `dp_clk_en_o` is 1 and `done_o` is 0. `dp_clk_o` toggles with `clk` from the next cycle on, while the block runs.
- R3: In exact mode the a-posteriori signs are sampled only in frame slot 5. A clean word that is present in every slot except slot 5 never ends a block early.
- R4: A word is error free when, for every check row c (bits c*n to c*n+n-1 of `H_MAT`, bit b of the row selecting sign bit b), the XOR of the selected sign bits is 0, where a sign bit of 1 means negative. In exact mode `edge_sign_i` has no effect.
- R5: In exact mode the decision is taken in slot 7 of the iteration whose slot-5 signs were clean. `done_o` is high in the cycle 8*k after the start, where k = `iter_count_o` = that iteration's index + 1.
- R6: When no decision ends the block, `done_o` rises in cycle 8*MAX_ITER with `exit_clean_o` = 0 and `iter_count_o` = MAX_ITER (13 by default). A clean decision in the last iteration still reports `exit_clean_o` = 1.
- R7: `done_o` is high for exactly one cycle. In that cycle `dec_word_o` holds the signs sampled in slot 5 of the last complete iteration that ended at or before the decision.
- R8: In approximate mode (`approx_i` = 1 at start), check row c takes message sign bit c*n+b from `edge_sign_i` for bit b, sampled in slot 5. The decision lands in slot 1 of the next iteration, so `done_o` appears in cycle 8*k-6 with k = sensed iteration index + 2. In this mode `app_sign_i` does not affect the decision.
- R9: After `done_o`, `dp_clk_en_o` is 0 and `dp_clk_o` stays low until the next `start_i`.
- R10: A `start_i` during a running block restarts it: the frame slots, the iteration count and the flags begin again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that loads a new block |
| approx_i | input | 1 | Mode captured at start: 0 exact, 1 approximate |
| app_sign_i | input | N_BITS | A-posteriori sign per bit, valid in slot 5 |
| edge_sign_i | input | M_CHECKS*N_BITS | Bit-to-check message signs, bit c*n+b for edge b to c |
| done_o | output | 1 | One-cycle end-of-block strobe |
| exit_clean_o | output | 1 | 1 if the block ended by early termination, 0 if by the cap |
| iter_count_o | output | ITER_W | Number of iterations run for the block |
| dec_word_o | output | N_BITS | Decided hard-decision word |
| dp_clk_en_o | output | 1 | Datapath clock enable |
| dp_clk_o | output | 1 | Gated datapath clock |

## Verification
The hardest cases to reach from the ports are the ones that turn on where inside the frame a sign is seen. One is a word that is clean in every slot except slot 5. Another is a message-sign view that disagrees with the a-posteriori view. The bench drives the sign inputs cycle by cycle from its own frame counter, so it can place a clean word in only one slot or only outside it, and it can let the edge signs become clean at a different iteration than the a-posteriori signs. It also drives the decisions that fall in the very last iteration in both modes, and a restart pulse in the middle of a block.

// File: rtl/ldpc_et_pkg.sv
// Package: shared frame constants and types for the early-termination controller.
// Assumes a fixed eight-slot iteration frame.
package ldpc_et_pkg;

    localparam int FRAME_W = 3;
    localparam logic [FRAME_W-1:0] SLOT_SIGN   = 3'd5;
    localparam logic [FRAME_W-1:0] SLOT_CHECK  = 3'd6;
    localparam logic [FRAME_W-1:0] SLOT_DECIDE = 3'd7;
    localparam int APPROX_LAG = 2;

    typedef struct packed {
        logic vld;
        logic clear;
    } sense_stage_t;

endpackage

// File: rtl/ldpc_check_nor.sv
// Module: ldpc_check_nor
// Forms the even-parity result of every check row over per-edge sign bits
// and reduces them with a NOR into one all-satisfied flag.
// Assumes H_MAT row c occupies bits c*N_BITS +: N_BITS.
module ldpc_check_nor #(
    parameter int N_BITS   = 8,
    parameter int M_CHECKS = 4,
    parameter logic [M_CHECKS*N_BITS-1:0] H_MAT = '0
) (
    input  logic [M_CHECKS*N_BITS-1:0] edge_sgn_i,
    output logic                       all_clear_o
);

    logic [M_CHECKS-1:0] odd_w;

    // One XOR tree per check row over the edges the row selects.
    for (genvar c = 0; c < M_CHECKS; c++) begin : g_row
        assign odd_w[c] = ^(edge_sgn_i[c*N_BITS +: N_BITS] & H_MAT[c*N_BITS +: N_BITS]);
    end

    // NOR of all row parities: high only when every check is satisfied.
    assign all_clear_o = ~|odd_w;

endmodule

// File: rtl/ldpc_frame_timer.sv
// Module: ldpc_frame_timer
// Counts slots inside an eight-slot frame and whole iterations.
// Assumes load has priority over run; counting holds while run is low.
module ldpc_frame_timer
    import ldpc_et_pkg::*;
#(
    parameter int MAX_ITER = 13,
    parameter int ITER_W   = $clog2(MAX_ITER + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               run_i,
    output logic [FRAME_W-1:0] slot_o,
    output logic [ITER_W-1:0]  iter_o,
    output logic               last_iter_o
);

    localparam logic [ITER_W-1:0] ITER_TOP = ITER_W'(MAX_ITER - 1);

    // Slot and iteration counters, cleared by reset or a new block.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i) begin
            slot_o <= '0;
            iter_o <= '0;
        end else if (run_i) begin
            slot_o <= slot_o + FRAME_W'(1);
            if (slot_o == SLOT_DECIDE) begin
                iter_o <= iter_o + ITER_W'(1);
            end
        end
    end

    assign last_iter_o = (iter_o == ITER_TOP);

endmodule

// File: rtl/ldpc_clk_gate.sv
// Module: ldpc_clk_gate
// Glitch-free clock gate: the enable passes a latch that is open while
// the clock is low, so it can only change the gated clock between pulses.
module ldpc_clk_gate (
    input  logic clk,
    input  logic en_i,
    output logic gclk_o
);

    logic en_lat;

    // Latch the enable during the low phase of the clock.
    always_latch begin
        if (!clk) begin
            en_lat = en_i;
        end
    end

    assign gclk_o = clk & en_lat;

endmodule

// File: rtl/ldpc_et_ctrl.sv
// Module: ldpc_et_ctrl (top)
// Early-termination controller for an iterative LDPC decoder. Samples
// a-posteriori signs in slot 5, registers the all-checks-clear flag in
// slot 6 and decides in slot 7. An approximate mode uses per-edge message
// signs with a two-cycle longer decision path. Releases the block at the
// iteration cap and gates the datapath clock when the block ends.
// Assumes start_i is a single-cycle pulse; mode is captured at start.
module ldpc_et_ctrl
    import ldpc_et_pkg::*;
#(
    parameter int N_BITS   = 8,
    parameter int M_CHECKS = 4,
    parameter logic [M_CHECKS*N_BITS-1:0] H_MAT = 32'h8B4D_2E17,
    parameter int MAX_ITER = 13,
    parameter int ITER_W   = $clog2(MAX_ITER + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic                       approx_i,
    input  logic [N_BITS-1:0]          app_sign_i,
    input  logic [M_CHECKS*N_BITS-1:0] edge_sign_i,
    output logic                       done_o,
    output logic                       exit_clean_o,
    output logic [ITER_W-1:0]          iter_count_o,
    output logic [N_BITS-1:0]          dec_word_o,
    output logic                       dp_clk_en_o,
    output logic                       dp_clk_o
);

    localparam int EDGES = M_CHECKS * N_BITS;

    logic                 active_q;
    logic                 approx_q;
    logic [N_BITS-1:0]    sign_q;
    logic [EDGES-1:0]     edge_q;
    logic                 exact_clr_q;
    logic                 apprx_clr_q;
    sense_stage_t         lag_q [APPROX_LAG];
    logic [FRAME_W-1:0]   slot_w;
    logic [ITER_W-1:0]    iter_w;
    logic                 last_iter_w;
    logic                 exact_clr_w;
    logic                 apprx_clr_w;
    logic                 decide_exact;
    logic                 decide_apprx;
    logic                 hit_cap;
    logic                 finish;

    u_frame_timer_block : begin end
    ldpc_frame_timer #(
        .MAX_ITER (MAX_ITER),
        .ITER_W   (ITER_W)
    ) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (start_i),
        .run_i       (active_q),
        .slot_o      (slot_w),
        .iter_o      (iter_w),
        .last_iter_o (last_iter_w)
    );

    ldpc_check_nor #(
        .N_BITS   (N_BITS),
        .M_CHECKS (M_CHECKS),
        .H_MAT    (H_MAT)
    ) u_exact (
        .edge_sgn_i  ({M_CHECKS{sign_q}}),
        .all_clear_o (exact_clr_w)
    );

    ldpc_check_nor #(
        .N_BITS   (N_BITS),
        .M_CHECKS (M_CHECKS),
        .H_MAT    (H_MAT)
    ) u_apprx (
        .edge_sgn_i  (edge_q),
        .all_clear_o (apprx_clr_w)
    );

    ldpc_clk_gate u_gate (
        .clk    (clk),
        .en_i   (active_q),
        .gclk_o (dp_clk_o)
    );

    assign decide_exact = active_q && !approx_q && (slot_w == SLOT_DECIDE) && exact_clr_q;
    assign decide_apprx = active_q && approx_q && lag_q[APPROX_LAG-1].vld
                          && lag_q[APPROX_LAG-1].clear;
    assign hit_cap      = active_q && (slot_w == SLOT_DECIDE) && last_iter_w;
    assign finish       = decide_exact || decide_apprx || hit_cap;
    assign dp_clk_en_o  = active_q;

    // Sign capture in the slot freed for the a-posteriori sign.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sign_q <= '0;
            edge_q <= '0;
        end else if (active_q && slot_w == SLOT_SIGN) begin
            sign_q <= app_sign_i;
            edge_q <= edge_sign_i;
        end
    end

    // Register both clear flags at the end of the check slot.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            exact_clr_q <= 1'b0;
            apprx_clr_q <= 1'b0;
        end else if (active_q && slot_w == SLOT_CHECK) begin
            exact_clr_q <= exact_clr_w;
            apprx_clr_q <= apprx_clr_w;
        end
    end

    // Extra delay stages of the approximate decision path.
    for (genvar s = 0; s < APPROX_LAG; s++) begin : g_lag
        always_ff @(posedge clk) begin
            if (!rst_n || start_i) begin
                lag_q[s] <= '0;
            end else if (s == 0) begin
                lag_q[s].vld   <= active_q && approx_q && (slot_w == SLOT_DECIDE);
                lag_q[s].clear <= apprx_clr_q;
            end else begin
                lag_q[s] <= lag_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    // Block state, mode capture and end-of-block outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q     <= 1'b0;
            approx_q     <= 1'b0;
            done_o       <= 1'b0;
            exit_clean_o <= 1'b0;
            iter_count_o <= '0;
            dec_word_o   <= '0;
        end else if (start_i) begin
            active_q     <= 1'b1;
            approx_q     <= approx_i;
            done_o       <= 1'b0;
            exit_clean_o <= 1'b0;
            iter_count_o <= '0;
        end else if (finish) begin
            active_q     <= 1'b0;
            done_o       <= 1'b1;
            exit_clean_o <= decide_exact || decide_apprx;
            iter_count_o <= iter_w + ITER_W'(1);
            dec_word_o   <= sign_q;
        end else begin
            done_o <= 1'b0;
        end
    end

endmodule

// File: rtl/ldpc_et_ctrl_chk.sv
// Module: ldpc_et_ctrl_chk
// Property checker for ldpc_et_ctrl, attached by bind below.
module ldpc_et_ctrl_chk #(
    parameter int MAX_ITER = 13,
    parameter int ITER_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              done_o,
    input logic              exit_clean_o,
    input logic [ITER_W-1:0] iter_count_o,
    input logic              dp_clk_en_o,
    input logic [2:0]        slot,
    input logic              approx_q
);

    assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (dp_clk_en_o && !done_o));

    assert_exact_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exit_clean_o && !approx_q) |-> ($past(slot) == 3'd7));

    assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (iter_count_o >= ITER_W'(1) && iter_count_o <= ITER_W'(MAX_ITER)));

    assert_cap_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !exit_clean_o) |-> (iter_count_o == ITER_W'(MAX_ITER)));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_approx_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exit_clean_o && approx_q) |-> ($past(slot) == 3'd1));

    assert_gate_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !dp_clk_en_o);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!dp_clk_en_o && !start_i) |=> !dp_clk_en_o);

endmodule

bind ldpc_et_ctrl ldpc_et_ctrl_chk #(
    .MAX_ITER (MAX_ITER),
    .ITER_W   (ITER_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .done_o       (done_o),
    .exit_clean_o (exit_clean_o),
    .iter_count_o (iter_count_o),
    .dp_clk_en_o  (dp_clk_en_o),
    .slot         (slot_w),
    .approx_q     (approx_q)
);

// File: tb/test_ldpc_et_ctrl.sv
`timescale 1ns/1ps
module test_ldpc_et_ctrl;

    localparam int N = 8;
    localparam int M = 4;
    localparam logic [M*N-1:0] HM = 32'h8B4D_2E17;

    typedef struct packed {
        logic       approx;
        logic [3:0] ci;
        logic [3:0] eci;
        logic [1:0] pat;
        logic [5:0] rs;
        logic [7:0] good;
        logic [7:0] bad;
        logic [3:0] cnt;
        logic       clean;
    } vec_t;

    // ci/eci: iteration where sign/edge view turns clean (15 = never)
    // pat: 0 clean all slots, 1 clean only slot 5, 2 clean all but slot 5
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd0,  4'd15, 2'd0, 6'd0,  8'h17, 8'h01, 4'd1,  1'b1}, // R5
        '{1'b0, 4'd3,  4'd0,  2'd0, 6'd0,  8'h2E, 8'h80, 4'd4,  1'b1}, // R4
        '{1'b0, 4'd12, 4'd0,  2'd0, 6'd0,  8'h00, 8'h01, 4'd13, 1'b1}, // R5/R6
        '{1'b0, 4'd15, 4'd0,  2'd0, 6'd0,  8'h00, 8'h01, 4'd13, 1'b0}, // R6
        '{1'b0, 4'd2,  4'd15, 2'd1, 6'd0,  8'h17, 8'h01, 4'd3,  1'b1}, // R3
        '{1'b0, 4'd2,  4'd15, 2'd2, 6'd0,  8'h17, 8'h01, 4'd13, 1'b0}, // R3
        '{1'b1, 4'd0,  4'd4,  2'd0, 6'd0,  8'h17, 8'h01, 4'd6,  1'b1}, // R8
        '{1'b1, 4'd15, 4'd1,  2'd0, 6'd0,  8'h2E, 8'h01, 4'd3,  1'b1}, // R8
        '{1'b1, 4'd0,  4'd11, 2'd0, 6'd0,  8'h17, 8'h80, 4'd13, 1'b1}, // R8
        '{1'b1, 4'd0,  4'd12, 2'd0, 6'd0,  8'h17, 8'h80, 4'd13, 1'b0}, // R6
        '{1'b0, 4'd1,  4'd15, 2'd0, 6'd20, 8'h17, 8'h01, 4'd2,  1'b1}  // R10
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic           approx_i = 1'b0;
    logic [N-1:0]   app_sign_i = '0;
    logic [M*N-1:0] edge_sign_i = '0;
    logic           done_o;
    logic           exit_clean_o;
    logic [3:0]     iter_count_o;
    logic [N-1:0]   dec_word_o;
    logic           dp_clk_en_o;
    logic           dp_clk_o;

    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    ldpc_et_ctrl i_ldpc_et_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .approx_i     (approx_i),
        .app_sign_i   (app_sign_i),
        .edge_sign_i  (edge_sign_i),
        .done_o       (done_o),
        .exit_clean_o (exit_clean_o),
        .iter_count_o (iter_count_o),
        .dec_word_o   (dec_word_o),
        .dp_clk_en_o  (dp_clk_en_o),
        .dp_clk_o     (dp_clk_o)
    );

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Even parity on every H row means error free.
    function automatic bit is_clean(input logic [N-1:0] w);
        for (int c = 0; c < M; c++) begin
            if (^(w & HM[c*N +: N])) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [N-1:0] sign_at(input vec_t v, input int c, input bit live);
        int it = c / 8;
        int sl = c % 8;
        if (!live || it < int'(v.ci)) return v.bad;
        case (v.pat)
            2'd1:    return (sl == 5) ? v.good : v.bad;
            2'd2:    return (sl == 5) ? v.bad : v.good;
            default: return v.good;
        endcase
    endfunction

    function automatic logic [M*N-1:0] edge_at(input vec_t v, input int c, input bit live);
        if (!live || (c / 8) < int'(v.eci)) return {M{v.bad}};
        return {M{v.good}};
    endfunction

    task automatic run_vec(input vec_t v, input int idx);
        int c;
        bit live;
        bit got;
        int sens;
        int exp_c;
        logic [N-1:0] exp_w;
        if (v.clean) check($sformatf("R4 v%0d good word is codeword", idx), is_clean(v.good), 1);
        check($sformatf("R4 v%0d bad word fails", idx), is_clean(v.bad), 0);
        @(negedge clk);
        start_i  = 1'b1;
        approx_i = v.approx;
        @(negedge clk);
        start_i = 1'b0;
        c = 0;
        live = (v.rs == 0);
        got = 1'b0;
        while (!got && c < 200) begin
            app_sign_i  = sign_at(v, c, live);
            edge_sign_i = edge_at(v, c, live);
            if (!live && c == int'(v.rs)) start_i = 1'b1;
            if (c == 0 && v.rs == 0) begin
                check($sformatf("R2 v%0d gate enable on", idx), dp_clk_en_o, 1);
                check($sformatf("R2 v%0d no done at start", idx), done_o, 0);
            end
            if (c == 1 && v.rs == 0) begin
                @(posedge clk);
                #5;
                check($sformatf("R2 v%0d gated clock runs", idx), dp_clk_o, 1);
            end
            @(negedge clk);
            start_i = 1'b0;
            if (!live && c == int'(v.rs)) begin
                live = 1'b1;
                c = 0;
            end else begin
                c++;
            end
            if (done_o) got = 1'b1;
        end
        exp_c = (v.clean && v.approx) ? 8 * int'(v.cnt) - 6 : 8 * int'(v.cnt);
        sens  = (v.clean && v.approx) ? int'(v.cnt) - 2 : int'(v.cnt) - 1;
        exp_w = sign_at(v, sens * 8 + 5, 1'b1);
        check($sformatf("R5/R8 v%0d done cycle", idx), c, exp_c);
        check($sformatf("R6 v%0d iteration count", idx), iter_count_o, v.cnt);
        check($sformatf("R6 v%0d exit status", idx), exit_clean_o, v.clean);
        check($sformatf("R7 v%0d decided word", idx), dec_word_o, exp_w);
        @(posedge clk);
        #5;
        check($sformatf("R9 v%0d gated clock stopped", idx), dp_clk_o, 0);
        @(negedge clk);
        check($sformatf("R7 v%0d done one cycle", idx), done_o, 0);
        check($sformatf("R9 v%0d gate enable off", idx), dp_clk_en_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done low in reset", done_o, 0);
        check("R1 gate off in reset", dp_clk_en_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done low after reset", done_o, 0);
        check("R1 status low after reset", exit_clean_o, 0);
        check("R1 count zero after reset", iter_count_o, 0);
        check("R1 gate off after reset", dp_clk_en_o, 0);
        @(posedge clk);
        #5;
        check("R1 gated clock low", dp_clk_o, 0);
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i);
        end
        // R9: idle gate stays off for several cycles without a start
        repeat (5) @(negedge clk);
        check("R9 idle gate stays off", dp_clk_en_o, 0);
        check("R9 idle no done", done_o, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule